// File: doc/BRIEF.md
# Event Page Ring Manager

This block keeps track of a ring of 64 event pages in a multi-event buffer. It holds the bookkeeping only: the data memory and the formatting of words live elsewhere. The front end reports each finished acquisition with a one-cycle `event_done` pulse. The event is committed to the next page unless `fast_clear` accompanies the pulse. The readout side steps through committed events with a load-next command or a skip command. Each of these moves the read pointer onto the oldest unread page, which then stays occupied while it is being read.

Because the page under the read pointer is in use, 63 of the 64 pages can hold unread events. The empty flag reports that no unread event is left beyond the page being read. So after the only stored event has been loaded, the block shows empty even though that event is ready for readout. While the ring is full, the busy output tells the front end to stop taking gates. A diagnostic write can force the read pointer to any page, and a load or skip against an empty ring raises a sticky error flag.

Top module: `evbuf_mgr`

## Requirements
- R1: After synchronous reset `wr_ptr` = 0, `rd_ptr` = 0, `empty` = 1, `full` = 0, `busy` = 0, `cmd_err` = 0 and `buf_num` = 0.
- R2: A cycle with `event_done`=1, `fast_clear`=0 and `full`=0 advances `wr_ptr` by one in the next cycle.
- R3: When `event_done` arrives together with `fast_clear`, `wr_ptr` does not change.
- R4: `empty` is 1 exactly when `wr_ptr` equals `rd_ptr`, and `full` is 1 exactly when `wr_ptr`+1 (mod 64) equals `rd_ptr`. Starting from reset, 63 commits make `full` = 1.
- R5: `busy` equals `full`. While `full` is 1, an `event_done` is dropped and `wr_ptr` stays unchanged.
- R6: `load_next` or `skip` while `empty`=0 (and no diagnostic write in that cycle) advances `rd_ptr` by one in the next cycle. Reading an event from a full ring clears `busy`.
- R7: `load_next` or `skip` while `empty`=1 leaves `rd_ptr` unchanged and sets `cmd_err`. `cmd_err` stays set until reset.
- R8: `diag_wr`=1 loads `rd_ptr` with `diag_page` in the next cycle. This takes priority over `load_next` and `skip` in the same cycle.
- R9: `buf_num` equals the two low bits of `rd_ptr`.
- R10: With one event stored, a `load_next` makes `empty` read 1.
- R11: Both pointers wrap from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_done | input | 1 | Acquisition of one event finished |
| fast_clear | input | 1 | Discard the event reported in the same cycle |
| load_next | input | 1 | Move readout to the next stored event |
| skip | input | 1 | Drop the next stored event (same pointer effect) |
| diag_wr | input | 1 | Diagnostic write of the read pointer |
| diag_page | input | 6 | Page loaded by a diagnostic write |
| wr_ptr | output | 6 | Last committed page |
| rd_ptr | output | 6 | Page currently being read |
| full | output | 1 | No free page left for another event |
| empty | output | 1 | No unread event beyond the read page |
| busy | output | 1 | Block new gates |
| buf_num | output | 2 | Read page number modulo 4 |
| cmd_err | output | 1 | Sticky: load or skip issued while empty |

## Verification
Both pointers are registered, and the flags are decoded from them without storage. So a wrong pointer value shows up on `full`, `empty` and `busy` in the same cycle that the pointer appears at the ports, one clock after the command that caused it. Off-by-one errors in the full decode stay hidden until the ring has taken its 63rd event. For that reason the bench fills the ring completely, pushes one extra event, and then wraps both pointers through page 0. An error state that is wrongly cleared or never set becomes visible at `cmd_err` on the first command issued against an empty ring.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
    localparam int PAGE_W   = 6;
    localparam int BUFNUM_W = 2;

    // operation selected for the read pointer in one cycle
    typedef enum logic [1:0] {
        RD_HOLD = 2'd0,
        RD_STEP = 2'd1,
        RD_LOAD = 2'd2,
        RD_FAIL = 2'd3
    } rd_op_e;

    typedef struct packed {
        logic full;
        logic empty;
    } ring_flags_t;

    function automatic rd_op_e pick_rd_op(logic diag, logic step_req, logic is_empty);
        if (diag)
            return RD_LOAD;
        else if (step_req && is_empty)
            return RD_FAIL;
        else if (step_req)
            return RD_STEP;
        return RD_HOLD;
    endfunction
endpackage

// File: rtl/evbuf_flags.sv
module evbuf_flags #(
    parameter int PAGE_W = evbuf_pkg::PAGE_W
) (
    input  logic [PAGE_W-1:0] wr_ptr,
    input  logic [PAGE_W-1:0] rd_ptr,
    output evbuf_pkg::ring_flags_t flags
);
    localparam logic [PAGE_W-1:0] ONE = PAGE_W'(1);

    always_comb begin
        flags.empty = (wr_ptr == rd_ptr);
        flags.full  = ((wr_ptr + ONE) == rd_ptr);
    end
endmodule

// File: rtl/evbuf_wr_ctl.sv
module evbuf_wr_ctl #(
    parameter int PAGE_W = evbuf_pkg::PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              event_done,
    input  logic              fast_clear,
    input  logic              full,
    output logic [PAGE_W-1:0] wr_ptr
);
    localparam logic [PAGE_W-1:0] ONE = PAGE_W'(1);

    logic commit;
    logic [PAGE_W-1:0] wr_q;

    assign commit = event_done && !fast_clear && !full;

    always_ff @(posedge clk) begin
        if (rst)
            wr_q <= '0;
        else if (commit)
            wr_q <= wr_q + ONE;
    end

    assign wr_ptr = wr_q;
endmodule

// File: rtl/evbuf_rd_ctl.sv
module evbuf_rd_ctl #(
    parameter int PAGE_W = evbuf_pkg::PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_next,
    input  logic              skip,
    input  logic              diag_wr,
    input  logic [PAGE_W-1:0] diag_page,
    input  logic              empty,
    output logic [PAGE_W-1:0] rd_ptr,
    output logic              cmd_err
);
    import evbuf_pkg::*;

    localparam logic [PAGE_W-1:0] ONE = PAGE_W'(1);

    rd_op_e op;
    logic [PAGE_W-1:0] rd_q;
    logic err_q;

    always_comb op = pick_rd_op(diag_wr, load_next || skip, empty);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (op)
                RD_LOAD: rd_q  <= diag_page;
                RD_STEP: rd_q  <= rd_q + ONE;
                RD_FAIL: err_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign rd_ptr  = rd_q;
    assign cmd_err = err_q;
endmodule

// File: rtl/evbuf_mgr.sv
module evbuf_mgr #(
    parameter int PAGE_W   = evbuf_pkg::PAGE_W,
    parameter int BUFNUM_W = evbuf_pkg::BUFNUM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                event_done,
    input  logic                fast_clear,
    input  logic                load_next,
    input  logic                skip,
    input  logic                diag_wr,
    input  logic [PAGE_W-1:0]   diag_page,
    output logic [PAGE_W-1:0]   wr_ptr,
    output logic [PAGE_W-1:0]   rd_ptr,
    output logic                full,
    output logic                empty,
    output logic                busy,
    output logic [BUFNUM_W-1:0] buf_num,
    output logic                cmd_err
);
    evbuf_pkg::ring_flags_t flags;

    evbuf_wr_ctl #(.PAGE_W(PAGE_W)) u_wr (
        .clk(clk), .rst(rst), .event_done(event_done), .fast_clear(fast_clear),
        .full(flags.full), .wr_ptr(wr_ptr)
    );

    evbuf_rd_ctl #(.PAGE_W(PAGE_W)) u_rd (
        .clk(clk), .rst(rst), .load_next(load_next), .skip(skip),
        .diag_wr(diag_wr), .diag_page(diag_page), .empty(flags.empty),
        .rd_ptr(rd_ptr), .cmd_err(cmd_err)
    );

    evbuf_flags #(.PAGE_W(PAGE_W)) u_flags (
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .flags(flags)
    );

    assign full    = flags.full;
    assign empty   = flags.empty;
    assign busy    = flags.full;
    assign buf_num = rd_ptr[BUFNUM_W-1:0];
endmodule

// File: rtl/evbuf_mgr_chk.sv
module evbuf_mgr_chk #(
    parameter int PAGE_W = evbuf_pkg::PAGE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              event_done,
    input logic              fast_clear,
    input logic              load_next,
    input logic              skip,
    input logic              diag_wr,
    input logic [PAGE_W-1:0] diag_page,
    input logic [PAGE_W-1:0] wr_ptr,
    input logic [PAGE_W-1:0] rd_ptr,
    input logic              full,
    input logic              empty,
    input logic              busy,
    input logic              cmd_err
);
    localparam logic [PAGE_W-1:0] ONE = PAGE_W'(1);

    // R2
    commit_step_chk: assert property (@(posedge clk) disable iff (rst)
        event_done && !fast_clear && !full |=> wr_ptr == $past(wr_ptr) + ONE);
    // R3
    fast_clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
        event_done && fast_clear |=> $stable(wr_ptr));
    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
    // R5
    busy_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> busy);
    // R5
    drop_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        full && event_done |=> $stable(wr_ptr));
    // R6
    read_step_chk: assert property (@(posedge clk) disable iff (rst)
        (load_next || skip) && !empty && !diag_wr |=> rd_ptr == $past(rd_ptr) + ONE);
    // R7
    empty_cmd_err_chk: assert property (@(posedge clk) disable iff (rst)
        (load_next || skip) && empty && !diag_wr |=> cmd_err && $stable(rd_ptr));
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> cmd_err);
    // R8
    diag_load_chk: assert property (@(posedge clk) disable iff (rst)
        diag_wr |=> rd_ptr == $past(diag_page));
endmodule

bind evbuf_mgr evbuf_mgr_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst(rst), .event_done(event_done), .fast_clear(fast_clear),
    .load_next(load_next), .skip(skip), .diag_wr(diag_wr), .diag_page(diag_page),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty), .busy(busy),
    .cmd_err(cmd_err)
);

// File: tb/evbuf_mgr_test.sv
module evbuf_mgr_test;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic event_done = 0, fast_clear = 0, load_next = 0, skip = 0, diag_wr = 0;
    logic [5:0] diag_page = '0;
    logic [5:0] wr_ptr, rd_ptr;
    logic full, empty, busy, cmd_err;
    logic [1:0] buf_num;

    int total = 0;
    int bad = 0;

    always #(PERIOD/2) clk = ~clk;

    evbuf_mgr uut (
        .clk(clk), .rst(rst), .event_done(event_done), .fast_clear(fast_clear),
        .load_next(load_next), .skip(skip), .diag_wr(diag_wr), .diag_page(diag_page),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty), .busy(busy),
        .buf_num(buf_num), .cmd_err(cmd_err)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one cycle of inputs after a falling edge, sample at the next one
    task automatic apply(logic ev, logic fc, logic ln, logic sk, logic dw, logic [5:0] dp);
        event_done = ev; fast_clear = fc; load_next = ln; skip = sk;
        diag_wr = dw; diag_page = dp;
        @(negedge clk);
        event_done = 0; fast_clear = 0; load_next = 0; skip = 0; diag_wr = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 wr_ptr", wr_ptr, 0);
        check("R1 rd_ptr", rd_ptr, 0);
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 busy", busy, 0);
        check("R1 cmd_err", cmd_err, 0);
        check("R1 R9 buf_num", buf_num, 0);
    endtask

    task automatic t_commit_and_clear();
        apply(1, 0, 0, 0, 0, 0);
        check("R2 wr_ptr after commit", wr_ptr, 1);
        check("R4 empty after commit", empty, 0);
        apply(1, 1, 0, 0, 0, 0);
        check("R3 wr_ptr after fast clear", wr_ptr, 1);
    endtask

    task automatic t_single_load();
        apply(0, 0, 1, 0, 0, 0);
        check("R6 rd_ptr after load", rd_ptr, 1);
        check("R10 empty after loading only event", empty, 1);
        check("R9 buf_num", buf_num, 1);
    endtask

    task automatic t_empty_cmd();
        apply(0, 0, 1, 0, 0, 0);
        check("R7 rd_ptr held", rd_ptr, 1);
        check("R7 cmd_err set", cmd_err, 1);
        apply(1, 0, 0, 0, 0, 0);
        check("R7 cmd_err sticky", cmd_err, 1);
    endtask

    task automatic t_fill_wrap();
        do_reset();
        check("R1 cmd_err cleared by reset", cmd_err, 0);
        for (int i = 0; i < 62; i++) apply(1, 0, 0, 0, 0, 0);
        check("R4 not full at 62", full, 0);
        apply(1, 0, 0, 0, 0, 0);
        check("R4 wr_ptr at 63", wr_ptr, 63);
        check("R4 full at 63", full, 1);
        check("R5 busy when full", busy, 1);
        apply(1, 0, 0, 0, 0, 0);
        check("R5 event dropped when full", wr_ptr, 63);
        apply(0, 0, 0, 1, 0, 0);
        check("R6 rd_ptr after skip", rd_ptr, 1);
        check("R6 busy cleared after skip", busy, 0);
        apply(1, 0, 0, 0, 0, 0);
        check("R11 wr_ptr wraps", wr_ptr, 0);
        check("R4 full again", full, 1);
        for (int i = 0; i < 63; i++) apply(0, 0, 1, 0, 0, 0);
        check("R11 rd_ptr wraps", rd_ptr, 0);
        check("R4 empty after draining", empty, 1);
        check("R7 no error while draining", cmd_err, 0);
    endtask

    task automatic t_diag();
        apply(1, 0, 0, 0, 0, 0);
        apply(0, 0, 1, 0, 1, 6'd5);
        check("R8 diag load wins over load_next", rd_ptr, 5);
        check("R9 buf_num for page 5", buf_num, 1);
        check("R7 no error on diag cycle", cmd_err, 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_commit_and_clear();
        t_single_load();
        t_empty_cmd();
        t_fill_wrap();
        t_diag();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule